// File: doc/BRIEF.md
# Stuck Bus Recovery Sequencer

This block supervises one side of a two-wire serial bus and frees it when a device has left it hung. A watchdog counts every clock cycle in which the synchronized SCL or SDA level is low and restarts whenever both lines are seen high. If the count reaches its limit, the block declares the bus stuck. It raises a disconnect signal that stops the normal bus drivers and sends a one-cycle request so the far side disconnects too. A disconnect request arriving from the far side also raises the disconnect signal, but it does not start a local recovery.

After the declaration, the block waits a fixed hold-off time. It then toggles SCL through its open-drain pull-down. Between pulses SCL is released high, and SDA is sampled while SCL is high. Clocking stops as soon as SDA is seen high, or once the pulse limit is reached. The block then forces a STOP condition. It pulses `done`, releases the disconnect and goes back to watching the bus. While the disable input is asserted, detection and recovery are both held off.

Top module: `bus_unstick_seq`

## Requirements
- R1: `stuck_req` rises after STUCK_CYCLES consecutive clock samples in which `scl_in` or `sda_in` is low. It is a single-cycle pulse, and `drv_off` is high in the same cycle.
- R2: Any single sample with both lines high restarts the low-time count from zero.
- R3: While `peer_stuck` is high, `drv_off` is high and neither pull-down output is asserted.
- R4: The first pull-down action (`scl_pull` or `sda_pull` equal to 1, meaning the line is driven low) appears exactly HOLDOFF_CYCLES cycles after the cycle in which `stuck_req` is high.
- R5: Every change of the pull-down outputs during recovery is exactly HALF_CYCLES cycles after the previous change. This gives SCL low and high halves of HALF_CYCLES cycles each, and the same spacing for the STOP steps.
- R6: SDA is sampled in the last cycle of each SCL high half, and also at the end of the hold-off when EARLY_SKIP is 1 (the default). A high sample ends clocking, so a slave that releases SDA during the high half of pulse k yields exactly k pulses. A slave that releases before the hold-off ends yields none.
- R7: No more than MAX_PULSES SCL pulses are issued, even if SDA stays low.
- R8: The STOP sequence proceeds in three steps:
  - `sda_pull` asserts in the same cycle as `scl_pull`.
  - `scl_pull` is then released while `sda_pull` stays asserted.
  - `sda_pull` is released last, with SCL not pulled.
- R9: `done` is a single-cycle pulse in the cycle `sda_pull` is released. `drv_off` is low in that cycle, and a new stuck condition is detected afresh afterwards.
- R10: While `inhibit` is high, no stuck condition is declared. If `inhibit` rises during recovery, all outputs other than a `peer_stuck`-driven `drv_off` are low from the following cycle.
- R11: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| inhibit | input | 1 | Disable from undervoltage, thermal or shutdown |
| peer_stuck | input | 1 | Disconnect notification from the far side |
| scl_pull | output | 1 | 1 = pull SCL low |
| sda_pull | output | 1 | 1 = pull SDA low |
| drv_off | output | 1 | Disable the normal bus drivers |
| stuck_req | output | 1 | One-cycle request to send the stuck message |
| done | output | 1 | One-cycle pulse when the STOP is complete |

## Verification
The bench builds the block with STUCK_CYCLES=24, HOLDOFF_CYCLES=7, HALF_CYCLES=3 and MAX_PULSES=4. With these values a full detection and recovery takes only a few dozen cycles. That makes it possible to sweep the SDA release point over every pulse index from 0 to MAX_PULSES+1. The sweep covers the early skip, each early exit, the exact pulse limit and the case past the limit. Short timers also make it cheap to probe the watchdog at STUCK_CYCLES-1 samples, together with the SCL-stuck case, the disable input and the far-side request.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;
   typedef enum logic [2:0] {
      ST_WATCH   = 3'd0,
      ST_HOLDOFF = 3'd1,
      ST_CLK_LO  = 3'd2,
      ST_CLK_HI  = 3'd3,
      ST_STOP_SU = 3'd4,
      ST_STOP_HD = 3'd5
   } unstick_state_e;
endpackage

// File: rtl/bus_unstick_lowtimer.sv
// Counts consecutive samples with a low bus line; flags the limit sample.
module bus_unstick_lowtimer #(
   parameter int unsigned LIMIT = 370000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic line_low,
   output logic expired
);
   localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!arm || !line_low) begin
         cnt <= '0;
      end else if (cnt != LAST) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign expired = arm && line_low && (cnt == LAST);
endmodule

// File: rtl/bus_unstick_phase.sv
// Loadable down-counter timing one sequencer phase.
module bus_unstick_phase #(
   parameter int unsigned CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] len_m1,
   output logic          last
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= len_m1;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = (cnt == '0);
endmodule

// File: rtl/bus_unstick_fsm.sv
// Recovery sequencer: hold-off, clock pulses, STOP, done.
module bus_unstick_fsm
   import bus_unstick_pkg::*;
#(
   parameter int unsigned HOLDOFF_CYCLES = 400,
   parameter int unsigned HALF_CYCLES    = 50,
   parameter int unsigned MAX_PULSES     = 16,
   parameter bit          EARLY_SKIP     = 1'b1,
   parameter int unsigned PH_W           = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           inhibit,
   input  logic           sda_in,
   input  logic           expired,
   input  logic           ph_last,
   output logic           ph_load,
   output logic [PH_W-1:0] ph_len_m1,
   output unstick_state_e state_o,
   output logic           stuck_req,
   output logic           done
);
   localparam int unsigned PW = $clog2(MAX_PULSES + 1);
   localparam logic [PW-1:0] LAST_PULSE = PW'(MAX_PULSES - 1);

   unstick_state_e st, nx;
   logic [PW-1:0]  pulses;
   logic           skip_clocks;

   // Variant: whether a free SDA at the end of the hold-off skips clocking.
   generate
      if (EARLY_SKIP) begin : g_skip
         assign skip_clocks = sda_in;
      end else begin : g_noskip
         assign skip_clocks = 1'b0;
      end
   endgenerate

   always_comb begin
      nx = st;
      case (st)
         ST_WATCH:   if (expired) nx = ST_HOLDOFF;
         ST_HOLDOFF: if (ph_last) nx = skip_clocks ? ST_STOP_SU : ST_CLK_LO;
         ST_CLK_LO:  if (ph_last) nx = ST_CLK_HI;
         ST_CLK_HI:  if (ph_last) nx = (sda_in || pulses == LAST_PULSE) ? ST_STOP_SU : ST_CLK_LO;
         ST_STOP_SU: if (ph_last) nx = ST_STOP_HD;
         ST_STOP_HD: if (ph_last) nx = ST_WATCH;
         default:    nx = ST_WATCH;
      endcase
      if (inhibit) nx = ST_WATCH;
   end

   assign ph_load   = (nx != st) && (nx != ST_WATCH);
   assign ph_len_m1 = (nx == ST_HOLDOFF) ? PH_W'(HOLDOFF_CYCLES - 1) : PH_W'(HALF_CYCLES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_WATCH;
         pulses    <= '0;
         stuck_req <= 1'b0;
         done      <= 1'b0;
      end else begin
         st        <= nx;
         stuck_req <= (st == ST_WATCH) && (nx == ST_HOLDOFF);
         done      <= (st == ST_STOP_HD) && (nx == ST_WATCH) && !inhibit;
         if (st == ST_WATCH) begin
            pulses <= '0;
         end else if (st == ST_CLK_HI && ph_last) begin
            pulses <= pulses + 1'b1;
         end
      end
   end

   assign state_o = st;
endmodule

// File: rtl/bus_unstick_seq.sv
// Top: stuck-low watchdog plus recovery sequencer for a two-wire bus.
module bus_unstick_seq
   import bus_unstick_pkg::*;
#(
   parameter int unsigned STUCK_CYCLES   = 370000,
   parameter int unsigned HOLDOFF_CYCLES = 400,
   parameter int unsigned HALF_CYCLES    = 50,
   parameter int unsigned MAX_PULSES     = 16,
   parameter bit          EARLY_SKIP     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic inhibit,
   input  logic peer_stuck,
   output logic scl_pull,
   output logic sda_pull,
   output logic drv_off,
   output logic stuck_req,
   output logic done
);
   localparam int unsigned PH_MAX = (HOLDOFF_CYCLES > HALF_CYCLES) ? HOLDOFF_CYCLES : HALF_CYCLES;
   localparam int unsigned PH_W   = (PH_MAX > 2) ? $clog2(PH_MAX) : 1;

   generate
      if (STUCK_CYCLES < 2) begin : g_bad_stuck
         $error("STUCK_CYCLES must be at least 2");
      end
      if (HOLDOFF_CYCLES < 1 || HALF_CYCLES < 1) begin : g_bad_phase
         $error("phase lengths must be at least 1");
      end
      if (MAX_PULSES < 1) begin : g_bad_pulses
         $error("MAX_PULSES must be at least 1");
      end
   endgenerate

   unstick_state_e  st;
   logic            expired;
   logic            ph_load;
   logic            ph_last;
   logic [PH_W-1:0] ph_len_m1;

   bus_unstick_lowtimer #(.LIMIT(STUCK_CYCLES)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      ((st == ST_WATCH) && !inhibit),
      .line_low (!(scl_in && sda_in)),
      .expired  (expired)
   );

   bus_unstick_phase #(.CW(PH_W)) phase_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (ph_load),
      .len_m1 (ph_len_m1),
      .last   (ph_last)
   );

   bus_unstick_fsm #(
      .HOLDOFF_CYCLES (HOLDOFF_CYCLES),
      .HALF_CYCLES    (HALF_CYCLES),
      .MAX_PULSES     (MAX_PULSES),
      .EARLY_SKIP     (EARLY_SKIP),
      .PH_W           (PH_W)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .inhibit   (inhibit),
      .sda_in    (sda_in),
      .expired   (expired),
      .ph_last   (ph_last),
      .ph_load   (ph_load),
      .ph_len_m1 (ph_len_m1),
      .state_o   (st),
      .stuck_req (stuck_req),
      .done      (done)
   );

   assign scl_pull = (st == ST_CLK_LO) || (st == ST_STOP_SU);
   assign sda_pull = (st == ST_STOP_SU) || (st == ST_STOP_HD);
   assign drv_off  = (st != ST_WATCH) || peer_stuck;
endmodule

// File: rtl/bus_unstick_chk.sv
// Property checker bound to the top module.
module bus_unstick_chk #(
   parameter int unsigned MAX_PULSES = 16
) (
   input logic clk,
   input logic rst_n,
   input logic inhibit,
   input logic scl_pull,
   input logic sda_pull,
   input logic drv_off,
   input logic stuck_req,
   input logic done
);
   localparam int unsigned CW = $clog2(MAX_PULSES + 2) + 1;

   logic [CW-1:0] pulse_cnt;
   logic          scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_cnt <= '0;
         scl_q     <= 1'b0;
      end else begin
         scl_q <= scl_pull;
         if (stuck_req) begin
            pulse_cnt <= '0;
         end else if (scl_pull && !scl_q && !sda_pull) begin
            pulse_cnt <= pulse_cnt + 1'b1;
         end
      end
   end

   assert_req_disconnect_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stuck_req |-> drv_off);
   assert_req_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stuck_req |=> !stuck_req);
   assert_pulse_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_cnt <= CW'(MAX_PULSES));
   assert_stop_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> scl_pull);
   assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull) |-> !scl_pull);
   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_with_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $fell(sda_pull));
   assert_inhibit_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |=> (!scl_pull && !sda_pull && !stuck_req && !done));
endmodule

bind bus_unstick_seq bus_unstick_chk #(.MAX_PULSES(MAX_PULSES)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .inhibit   (inhibit),
   .scl_pull  (scl_pull),
   .sda_pull  (sda_pull),
   .drv_off   (drv_off),
   .stuck_req (stuck_req),
   .done      (done)
);

// File: tb/bus_unstick_seq_tb_top.sv
module bus_unstick_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int STUCK = 24;
   localparam int HOLD  = 7;
   localparam int HALF  = 3;
   localparam int MAXP  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_in = 1'b1;
   logic sda_in = 1'b1;
   logic inhibit = 1'b0;
   logic peer_stuck = 1'b0;
   logic scl_pull, sda_pull, drv_off, stuck_req, done;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_unstick_seq #(
      .STUCK_CYCLES   (STUCK),
      .HOLDOFF_CYCLES (HOLD),
      .HALF_CYCLES    (HALF),
      .MAX_PULSES     (MAXP)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_in     (scl_in),
      .sda_in     (sda_in),
      .inhibit    (inhibit),
      .peer_stuck (peer_stuck),
      .scl_pull   (scl_pull),
      .sda_pull   (sda_pull),
      .drv_off    (drv_off),
      .stuck_req  (stuck_req),
      .done       (done)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_stuck(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!stuck_req && n < 4 * STUCK);
   endtask

   // One detection and recovery; slave frees SDA after seeing k SCL rises.
   task automatic run_case(input int k, input bit scl_stuck);
      int n, t, first_act, last_evt, pulses, rises, stop_start, done_t, reqs, gap_bad, drv_bad, exp_p;
      bit sp, dp, psp, pdp;
      scl_in = 1'b1; sda_in = 1'b1;
      repeat (3) @(negedge clk);
      if (scl_stuck) scl_in = 1'b0; else sda_in = 1'b0;
      wait_stuck(n);
      chk(n == STUCK, "R1", "samples to stuck declaration", n, STUCK);
      chk(drv_off == 1'b1, "R1", "drv_off at declaration", drv_off, 1);
      scl_in = 1'b1;
      if (k == 0) sda_in = 1'b1;
      t = 0; first_act = -1; last_evt = -1; pulses = 0; rises = 0;
      stop_start = -1; done_t = -1; reqs = 1; gap_bad = 0; drv_bad = 0;
      psp = 1'b0; pdp = 1'b0;
      while (done_t < 0 && t < 2000) begin
         @(negedge clk);
         t++;
         sp = scl_pull; dp = sda_pull;
         if (stuck_req) reqs++;
         if (first_act < 0 && (sp || dp)) begin
            first_act = t;
            last_evt = t;
         end else if (first_act >= 0 && (sp != psp || dp != pdp)) begin
            if (t - last_evt != HALF) gap_bad++;
            last_evt = t;
         end
         if (sp && !psp && !dp) pulses++;
         if (psp && !sp && !dp) rises++;
         if (k > 0 && rises >= k) sda_in = 1'b1;
         scl_in = !sp;
         if (dp && !pdp) begin
            chk(sp == 1'b1, "R8", "SCL held low as SDA is pulled", sp, 1);
            stop_start = t;
         end
         if (pdp && dp && psp && !sp)
            chk(t - stop_start == HALF, "R8", "SCL released while SDA low", t - stop_start, HALF);
         if (pdp && !dp) begin
            chk(!sp && done, "R9", "done with SDA release, SCL free", {sp, done}, 1);
            chk(drv_off == 1'b0, "R9", "drv_off falls at done", drv_off, 0);
            done_t = t;
         end else if (done) begin
            chk(1'b0, "R9", "done outside SDA release", 1, 0);
         end
         if (done_t < 0 && !drv_off) drv_bad++;
         psp = sp; pdp = dp;
      end
      chk(done_t >= 0, "R9", "recovery completed", done_t >= 0, 1);
      chk(first_act == HOLD, "R4", "cycles from request to first action", first_act, HOLD);
      chk(gap_bad == 0, "R5", "phase spacing violations", gap_bad, 0);
      chk(drv_bad == 0, "R1", "drv_off drop during recovery", drv_bad, 0);
      chk(reqs == 1, "R1", "stuck_req pulses per recovery", reqs, 1);
      exp_p = scl_stuck ? 0 : ((k < MAXP) ? k : MAXP);
      if (k >= MAXP)
         chk(pulses == exp_p, "R7", "pulse count capped", pulses, exp_p);
      else
         chk(pulses == exp_p, "R6", "pulse count on SDA release", pulses, exp_p);
      @(negedge clk);
      chk(done == 1'b0, "R9", "done width", done, 0);
      scl_in = 1'b1; sda_in = 1'b1;
   endtask

   initial begin
      int n, seen;
      repeat (3) @(negedge clk);
      chk({scl_pull, sda_pull, drv_off, stuck_req, done} == 5'b0, "R11", "outputs in reset",
          {scl_pull, sda_pull, drv_off, stuck_req, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({scl_pull, sda_pull, drv_off, stuck_req, done} == 5'b0, "R11", "outputs after reset",
          {scl_pull, sda_pull, drv_off, stuck_req, done}, 0);

      // R3: far-side request only disables drivers
      peer_stuck = 1'b1;
      repeat (3) @(negedge clk);
      chk(drv_off == 1'b1, "R3", "drv_off with peer request", drv_off, 1);
      chk(!scl_pull && !sda_pull, "R3", "no pull from peer request", {scl_pull, sda_pull}, 0);
      peer_stuck = 1'b0;
      @(negedge clk);
      chk(drv_off == 1'b0, "R3", "drv_off after peer clears", drv_off, 0);

      // R2: one high sample restarts the count
      sda_in = 1'b0;
      seen = 0;
      repeat (STUCK - 1) begin
         @(negedge clk);
         if (stuck_req) seen++;
      end
      sda_in = 1'b1;
      @(negedge clk);
      if (stuck_req) seen++;
      chk(seen == 0, "R2", "no declaration below limit", seen, 0);
      sda_in = 1'b0;
      wait_stuck(n);
      chk(n == STUCK, "R2", "full count after restart", n, STUCK);

      // R10: inhibit aborts recovery and blocks detection
      inhibit = 1'b1;
      @(negedge clk);
      chk({scl_pull, sda_pull, drv_off} == 3'b0, "R10", "outputs after inhibit",
          {scl_pull, sda_pull, drv_off}, 0);
      seen = 0;
      repeat (2 * STUCK) begin
         @(negedge clk);
         if (stuck_req || scl_pull || sda_pull) seen++;
      end
      chk(seen == 0, "R10", "activity while inhibited", seen, 0);
      sda_in = 1'b1;
      inhibit = 1'b0;
      repeat (2) @(negedge clk);

      // R6/R7 sweep over SDA release point, then SCL-stuck case
      for (int k = 0; k <= MAXP + 1; k++) run_case(k, 1'b0);
      run_case(0, 1'b1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL R9 watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule